// File: doc/BRIEF.md
# Per-Area Memory Wait-State Controller

This block paces external bus cycles for a processor whose address space is divided into four areas. The area is taken from two upper address bits when an access request is accepted. A configuration register holds a 2-bit short-wait code for every area. The short code either gives the wait count directly or, when it is all ones, hands over to a 2-bit long-wait code. Areas 0 and 1 each have their own long-wait code, and areas 2 and 3 share one. The block counts the waits and then signals cycle-complete for one clock.

Before an access starts, the block decides whether it must obtain bus ownership from an external arbiter. In the normal case every access requests the bus. A partial-share setting, which applies only while the block is bus master, limits requests to area 2. When a request is raised, counting is held until the grant is seen. The same register also holds an address-monitor enable, which is exported gated off by partial-share, and a burst-ROM marker for area 0, which is exported unchanged.

Top module: `area_wait_ctrl`

## Requirements
- R1: Short-wait codes 00, 01 and 10 insert 0, 1 and 2 waits. When no bus request is needed, an access accepted at clock edge E drives `done` high after edge E+N+1, where N is the wait count.
- R2: A short-wait code of 11 selects the long-wait code. Long code 00 gives 3 waits, 01 gives 4, 10 gives 5 and 11 gives 6.
- R3: The area is `addr[26:25]`. The short-wait code of area n sits at `cfg_wdata[2n+1:2n]`. The long-wait code of area 0 is at `[9:8]` and that of area 1 at `[11:10]`. Areas 2 and 3 both use `[13:12]`.
- R4: After reset, every short and long code is 11, so any access takes 6 waits. Partial-share, monitor enable and burst-ROM are 0. `breq`, `busy` and `done` are low.
- R5: With `bus_master` high and partial-share (`cfg_wdata[15]`) set, `breq` is raised only for area 2 accesses. Accesses to the other areas complete without it.
- R6: Every other access raises `breq` from acceptance until `done`, and counting starts at the edge where `bgrant` is seen. If that edge is G, `done` goes high after edge G+N+1.
- R7: `done` lasts exactly one clock. `req` is ignored while `busy` is high.
- R8: `mon_en` equals the stored monitor bit (`cfg_wdata[14]`) AND NOT partial-share.
- R9: `brom_en` follows the stored burst-ROM bit (`cfg_wdata[16]`).
- R10: A configuration write made during an access does not change that access's wait count or its bus-request decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 17 | Configuration register write data |
| req | input | 1 | Access request, accepted when idle |
| addr | input | 27 | Access address |
| bus_master | input | 1 | High when this side is bus master |
| bgrant | input | 1 | Bus grant from the arbiter |
| breq | output | 1 | Bus ownership request |
| busy | output | 1 | Access in progress |
| done | output | 1 | Cycle-complete pulse |
| mon_en | output | 1 | Effective address-monitor enable |
| brom_en | output | 1 | Area 0 burst-ROM marker |

## Verification
The assertions assume that `bgrant` is raised only in answer to `breq` and is held until the access completes. They also assume that `req` is a single-cycle pulse. The stimulus follows these assumptions. The bench raises the grant a random 0 to 3 cycles after it sees `breq` and drops it only after `done`. It pulses `req` only once per access, plus one deliberate pulse while the block is busy. Configuration writes happen at random, both between accesses and in the middle of them.

// File: rtl/area_wait_ctrl.sv
module area_wait_ctrl #(
  parameter int ADDR_W   = 27,
  parameter int AREA_LSB = 25,
  parameter int CFG_W    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_master,
  input  logic              bgrant,
  output logic              breq,
  output logic              busy,
  output logic              done,
  output logic              mon_en,
  output logic              brom_en
);
  localparam int LW0 = 8, LW1 = 10, LW23 = 12, MON = 14, PSH = 15, BROM = 16;
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(14'h3fff);

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_WAIT, S_DONE} st_t;

  st_t              st_q;
  logic [CFG_W-1:0] cfg_q;
  logic [2:0]       cnt_q;
  logic [1:0]       area_q;
  logic             need_q, pshm_q;
  logic [1:0]       area_in;
  logic             unused_addr_bits;

  assign area_in          = addr[AREA_LSB +: 2];
  assign unused_addr_bits = ^addr[AREA_LSB-1:0];

  function automatic logic [2:0] waits_of(input logic [CFG_W-1:0] c, input logic [1:0] a);
    logic [1:0] s, l;
    s = c[2*a +: 2];
    if (s != 2'b11) return {1'b0, s};
    case (a)
      2'd0:    l = c[LW0 +: 2];
      2'd1:    l = c[LW1 +: 2];
      default: l = c[LW23 +: 2];
    endcase
    return 3'd3 + {1'b0, l};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      area_q <= '0;
      need_q <= 1'b0;
      pshm_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req) begin
          area_q <= area_in;
          cnt_q  <= waits_of(cfg_q, area_in);
          pshm_q <= bus_master && cfg_q[PSH];
          need_q <= !(bus_master && cfg_q[PSH] && area_in != 2'd2);
          st_q   <= (bus_master && cfg_q[PSH] && area_in != 2'd2) ? S_WAIT : S_ARB;
        end
        S_ARB:  if (bgrant) st_q <= S_WAIT;
        S_WAIT: if (cnt_q == 3'd0) st_q <= S_DONE;
                else cnt_q <= cnt_q - 3'd1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy    = st_q != S_IDLE;
  assign breq    = busy && need_q;
  assign done    = st_q == S_DONE;
  assign mon_en  = cfg_q[MON] && !cfg_q[PSH];
  assign brom_en = cfg_q[BROM];

  a_r1_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 3'd6);
  a_r5_partial_share_area2: assert property (@(posedge clk) disable iff (!rst_n)
    (breq && pshm_q) |-> area_q == 2'd2);
  a_r6_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ARB && !bgrant) |=> st_q == S_ARB);
  a_r6_breq_through_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ARB) |-> breq);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q == S_WAIT && cnt_q == 3'd0));
  a_r8_monitor_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[PSH] |-> !mon_en);
endmodule

// File: tb/area_wait_ctrl_bench.sv
module area_wait_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, req = 0, bus_master = 0, bgrant = 0;
  logic [16:0] cfg_wdata = '0;
  logic [26:0] addr = '0;
  logic breq, busy, done, mon_en, brom_en;

  int checks = 0, fails = 0;
  logic [16:0] cfgm = 17'h03fff;

  area_wait_ctrl u_area_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .addr(addr), .bus_master(bus_master), .bgrant(bgrant),
    .breq(breq), .busy(busy), .done(done), .mon_en(mon_en), .brom_en(brom_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_waits(input logic [16:0] c, input int a);
    int s;
    s = int'(c[2*a +: 2]);
    if (s != 3) return s;
    if (a == 0) return 3 + int'(c[9:8]);
    if (a == 1) return 3 + int'(c[11:10]);
    return 3 + int'(c[13:12]);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_status();
    chk(mon_en == (cfgm[14] && !cfgm[15]), "R8 mon_en", int'(mon_en), int'(cfgm[14] && !cfgm[15]));
    chk(brom_en == cfgm[16], "R9 brom_en", int'(brom_en), int'(cfgm[16]));
  endtask

  task automatic write_cfg(input logic [16:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    cfgm = v;
    chk_status();
  endtask

  task automatic run(input int ar, input bit m, input int gd, input bit mid);
    int n, edges, gcnt, gedge, dedge, expd;
    bit need, saw;
    logic [16:0] nv;
    need = !(m && cfgm[15] && ar != 2);
    n = exp_waits(cfgm, ar);
    nv = 17'($urandom);
    @(negedge clk);
    addr = {2'(ar), 25'($urandom)}; bus_master = m; req = 1;
    @(posedge clk); edges = 1;
    @(negedge clk); req = 0;
    if (mid) begin cfg_we = 1; cfg_wdata = nv; end
    gcnt = 0; gedge = -1; dedge = -1; saw = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 1 && mid) begin
        cfg_we = 0; req = 1; addr = {2'($urandom), 25'd0};
      end else if (i == 2 && mid) req = 0;
      if (breq) saw = 1;
      if (done) begin dedge = edges; break; end
      if (breq && !bgrant) begin
        if (gcnt == gd) begin bgrant = 1; gedge = edges + 1; end
        else gcnt++;
      end
      @(posedge clk); edges++;
      @(negedge clk);
    end
    req = 0; cfg_we = 0;
    if (mid) cfgm = nv;
    chk(saw == need, need ? "R6 breq raised" : "R5 breq suppressed", int'(saw), int'(need));
    expd = need ? gedge + n + 1 : n + 2;
    chk(dedge == expd, mid ? "R10 latency with mid-access write" :
        (n > 2 ? "R2 long wait latency" : "R1 short wait latency"), dedge, expd);
    @(negedge clk);
    chk(!done && !busy, "R7 done one cycle", int'(done), 0);
    bgrant = 0;
    if (mid) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (done || busy) begin
          chk(0, "R7 req while busy ignored", int'(busy), 0);
          break;
        end
      end
      chk_status();
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(!breq && !busy && !done, "R4 outputs idle", int'({breq, busy, done}), 0);
    chk(!mon_en && !brom_en, "R4 status reset", int'({mon_en, brom_en}), 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 0, 0);
    run(3, 1, 2, 0);
    // R3 area decode: distinct codes per area, areas 2 and 3 share [13:12]
    write_cfg({3'b000, 2'b01, 2'b10, 2'b00, 2'b11, 2'b11, 2'b10, 2'b01, 2'b00});
    run(0, 0, 0, 0); run(1, 0, 1, 0); run(2, 0, 0, 0); run(3, 0, 0, 0);
    write_cfg({3'b000, 2'b01, 2'b10, 2'b00, 8'hff});
    for (int a = 0; a < 4; a++) run(a, 0, 0, 0);
    // R5 partial share in master mode, then slave mode
    write_cfg({3'b011, 2'b00, 2'b00, 2'b00, 8'h1b});
    for (int a = 0; a < 4; a++) run(a, 1, 1, 0);
    for (int a = 0; a < 4; a++) run(a, 0, 0, 0);
    write_cfg({3'b101, 6'd0, 8'h00});
    run(1, 0, 0, 1);
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) write_cfg(17'($urandom));
      run(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 3)),
          $urandom_range(0, 7) == 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule